// File: doc/BRIEF.md
# Envelope-Swept Bandpass Wah Filter

This block applies an auto-wah to a mono sample stream. A second-order bandpass filter runs on each incoming sample. Its centre frequency moves with the loudness of the signal itself. A follower tracks that loudness by smoothing the squared input. The smoothed level, scaled by a swing setting and added to a fixed offset, gives a normalised tuning value `w = ω0·Ts/2`. From `w` and the quality factor Q, the block works out the biquad coefficients of the bilinear-transformed bandpass. It does this with one shared sequential divider, in the background between samples.

The result is used as a streaming element. The host drives `in_valid` once per audio sample, with at least 170 clocks between strobes at the default widths. Q, offset and swing may be changed while the stream runs. Each output sample leaves one clock after its strobe, and it already contains the contribution of the sample that produced it.

Top module: `wah_filter`

## Requirements
- R1: `out_valid` is high in exactly the clock after each clock with `in_valid` high and low otherwise; `out_sample` changes only in those clocks and holds its value while no strobe arrives.
- R2: After reset `out_valid` and `out_sample` are 0, and the first sample accepted after reset produces an output of exactly 0 (the coefficient set starts all zero).
- R3: The envelope `e` (unsigned, 1.0 = 2^23) is updated on each strobe as `e += floor((s − e) / 2^ENV_SHIFT)`, where `s = floor(x²·2^23)` in the same scale and `x` is the Q1.23 input.
- R4: The tuning value is `w = freq_offset + floor(swing·e)` (both settings unsigned with 2^23 = 1.0), clamped to at most 1.0.
- R5: With `q_factor` unsigned with 2^12 = 1.0 and `D = w + Q + Q·w²`, the coefficients (Q3.21, truncated toward zero) are `b0 = w/D`, `a1 = 2(Q·w² − Q)/D` and `a2 = (Q·w² − w + Q)/D`. These equal a/d, 2(1−b)/d and (1−a+b)/d with a = 2/(Q·ω0·Ts), b = 4/(ω0·Ts)², d = a+b+1.
- R6: The filter is direct form II: `v[n] = x[n] − a1·v[n−1] − a2·v[n−2]` and `y[n] = b0·v[n] − b0·v[n−2]`; there is no middle numerator term, and the outer numerator terms are equal and opposite.
- R7: The coefficient set used for sample n (n ≥ 1) is computed from the envelope after sample n−2 and from the settings present at strobe n−2 (for n = 1, the values right after reset). A new set replaces the old one as a whole at a strobe edge.
- R8: Output sample n already responds to input sample n: an impulse on an otherwise silent, settled filter appears as `b0·x` in the output of that same sample.
- R9: The delay state `v` saturates at ±2^(STATE_W−24) (±256 by default), and `out_sample` saturates at the Q1.23 limits; neither wraps.
- R10: Changing Q or offset while the stream runs takes effect through the R7 pipeline, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-clock strobe per input sample |
| in_sample | input | DATA_W | Input sample, signed Q1.23 |
| q_factor | input | Q_W | Quality factor, unsigned, 2^Q_FRAC = 1.0 |
| freq_offset | input | DATA_W | Base tuning value, unsigned, 2^23 = 1.0 |
| swing | input | DATA_W | Envelope-to-tuning gain, unsigned, 2^23 = 1.0 |
| out_valid | output | 1 | High one clock after each strobe |
| out_sample | output | DATA_W | Filtered sample, signed Q1.23 |

## Verification
The bench builds the block with its default widths: 24-bit data, Q3.21 coefficients, a 32-bit state and an envelope shift of 4. Its reference is a real-valued model with a tolerance of about 1e-3. The shift of 4 lets a sine burst move the envelope, and with it the coefficients, within a few dozen samples. This puts the two-sample coefficient pipeline in reach of a short run. The ±256 state range is reached within fifty samples of a full-scale DC input at a low tuning value. The offset-plus-swing sum can be driven past 1.0, which exercises the tuning clamp.

// File: rtl/wah_pkg.sv
package wah_pkg;

   typedef enum logic [1:0] {
      CE_IDLE = 2'd0,
      CE_DIV  = 2'd1,
      CE_HOLD = 2'd2
   } coef_state_e;

   // Clamp a signed value to the range of a signed field of the given width.
   function automatic logic signed [63:0] clamp_s64(input logic signed [63:0] v,
                                                    input int unsigned     bits);
      logic signed [63:0] hi;
      logic signed [63:0] lo;
      hi = (64'sd1 <<< (bits - 1)) - 64'sd1;
      lo = -(64'sd1 <<< (bits - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/wah_env_follower.sv
module wah_env_follower #(
   parameter int DATA_W    = 24,
   parameter int ENV_SHIFT = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   output logic        [DATA_W-1:0] env
);
   localparam int F = DATA_W - 1;

   logic signed [2*DATA_W-1:0] sq_full;
   logic        [DATA_W-1:0]   sq;
   logic        [DATA_W-1:0]   env_next;

   assign sq_full = in_sample * in_sample;
   assign sq      = sq_full[F +: DATA_W];

   generate
      if (ENV_SHIFT == 0) begin : g_direct
         assign env_next = sq;
      end else begin : g_smooth
         logic signed [DATA_W:0] diff;
         logic signed [DATA_W:0] step;
         logic signed [DATA_W:0] sum;
         assign diff     = $signed({1'b0, sq}) - $signed({1'b0, env});
         assign step     = diff >>> ENV_SHIFT;
         assign sum      = $signed({1'b0, env}) + step;
         assign env_next = sum[DATA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        env <= '0;
      else if (in_valid) env <= env_next;
   end
endmodule

// File: rtl/wah_seq_divider.sv
module wah_seq_divider #(
   parameter int NUM_W = 30,
   parameter int DEN_W = 29,
   parameter int FRAC  = 21,
   parameter int QUO_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [NUM_W-1:0] num,
   input  logic        [DEN_W-1:0] den,
   output logic                    done,
   output logic signed [QUO_W-1:0] quo
);
   localparam int BITS = NUM_W + FRAC;
   localparam int CW   = $clog2(BITS + 1);

   logic [BITS-1:0]  dvd;
   logic [BITS-1:0]  acc;
   logic [DEN_W-1:0] rem;
   logic [CW-1:0]    cnt;
   logic             busy;
   logic             neg;

   logic [NUM_W-1:0] mag_in;
   logic [DEN_W:0]   trial;
   logic             ge;
   logic [DEN_W:0]   trial_sub;
   logic             fits;
   logic [QUO_W-2:0] q_mag;

   assign mag_in    = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
   assign trial     = {rem, dvd[BITS-1]};
   assign ge        = trial >= {1'b0, den};
   assign trial_sub = trial - {1'b0, den};
   assign fits      = (acc >> (QUO_W - 1)) == '0;
   assign q_mag     = fits ? acc[QUO_W-2:0] : '1;
   assign quo       = neg ? -$signed({1'b0, q_mag}) : $signed({1'b0, q_mag});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvd  <= '0;
         acc  <= '0;
         rem  <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         neg  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            dvd  <= {mag_in, {FRAC{1'b0}}};
            acc  <= '0;
            rem  <= '0;
            neg  <= num[NUM_W-1];
            cnt  <= CW'(BITS);
            busy <= 1'b1;
         end else if (busy) begin
            rem <= ge ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
            acc <= {acc[BITS-2:0], ge};
            dvd <= dvd << 1;
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wah_coef_engine.sv
module wah_coef_engine
   import wah_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int COEF_W    = 24,
   parameter int COEF_FRAC = 21,
   parameter int Q_W       = 16,
   parameter int Q_FRAC    = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  logic        [DATA_W-1:0] env,
   input  logic        [DATA_W-1:0] offset,
   input  logic        [DATA_W-1:0] swing,
   input  logic        [Q_W-1:0]    q,
   output logic signed [COEF_W-1:0] b0,
   output logic signed [COEF_W-1:0] a1,
   output logic signed [COEF_W-1:0] a2
);
   localparam int F     = DATA_W - 1;
   localparam int QS_W  = Q_W + F - Q_FRAC;
   localparam int DEN_W = QS_W + 2;
   localparam int NUM_W = QS_W + 3;
   localparam logic [DATA_W+1:0] ONE_W = (DATA_W + 2)'(1) << F;

   // tuning value
   logic [2*DATA_W-1:0]   sw_prod;
   logic [DATA_W+1:0]     w_sum;
   logic [DATA_W-1:0]     w_c;
   logic [2*DATA_W-1:0]   ww_full;
   logic [DATA_W-1:0]     ww;
   logic [Q_W+DATA_W-1:0] qww_full;
   logic [QS_W-1:0]       qww;
   logic [QS_W-1:0]       qs;
   logic [DEN_W-1:0]      den;
   logic signed [NUM_W-1:0] n0, n1, n2;

   assign sw_prod  = swing * env;
   assign w_sum    = {1'b0, offset} + {1'b0, sw_prod[F +: DATA_W+1]};
   assign w_c      = (w_sum > ONE_W) ? ONE_W[DATA_W-1:0] : w_sum[DATA_W-1:0];
   assign ww_full  = w_c * w_c;
   assign ww       = ww_full[F +: DATA_W];
   assign qww_full = q * ww;
   assign qww      = qww_full[Q_FRAC +: QS_W];
   assign qs       = QS_W'(q) << (F - Q_FRAC);
   assign den      = DEN_W'(w_c) + DEN_W'(qs) + DEN_W'(qww);
   assign n0       = $signed(NUM_W'(w_c));
   assign n1       = ($signed(NUM_W'(qww)) - $signed(NUM_W'(qs))) <<< 1;
   assign n2       = $signed(NUM_W'(qww)) + $signed(NUM_W'(qs)) - $signed(NUM_W'(w_c));

   coef_state_e state;
   logic [1:0]  idx;
   logic        start_q;
   logic signed [NUM_W-1:0] n0_r, n1_r, n2_r, num_sel;
   logic        [DEN_W-1:0] den_r;
   logic signed [COEF_W-1:0] pb0, pa1, pa2, quo;
   logic        div_done;

   assign num_sel = (idx == 2'd0) ? n0_r : (idx == 2'd1) ? n1_r : n2_r;

   wah_seq_divider #(
      .NUM_W(NUM_W), .DEN_W(DEN_W), .FRAC(COEF_FRAC), .QUO_W(COEF_W)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .start(start_q),
      .num(num_sel), .den(den_r), .done(div_done), .quo(quo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= CE_IDLE;
         idx     <= '0;
         start_q <= 1'b0;
         n0_r    <= '0;
         n1_r    <= '0;
         n2_r    <= '0;
         den_r   <= '0;
         pb0     <= '0;
         pa1     <= '0;
         pa2     <= '0;
         b0      <= '0;
         a1      <= '0;
         a2      <= '0;
      end else begin
         start_q <= 1'b0;
         case (state)
            CE_IDLE: begin
               n0_r    <= n0;
               n1_r    <= n1;
               n2_r    <= n2;
               den_r   <= den;
               idx     <= 2'd0;
               start_q <= 1'b1;
               state   <= CE_DIV;
            end
            CE_DIV: begin
               if (div_done) begin
                  case (idx)
                     2'd0:    pb0 <= quo;
                     2'd1:    pa1 <= quo;
                     default: pa2 <= quo;
                  endcase
                  if (idx == 2'd2) begin
                     state <= CE_HOLD;
                  end else begin
                     idx     <= idx + 2'd1;
                     start_q <= 1'b1;
                  end
               end
            end
            default: begin
               if (commit) begin
                  b0    <= pb0;
                  a1    <= pa1;
                  a2    <= pa2;
                  state <= CE_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/wah_biquad_df2.sv
module wah_biquad_df2
   import wah_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int COEF_W    = 24,
   parameter int COEF_FRAC = 21,
   parameter int STATE_W   = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic signed [COEF_W-1:0] b0,
   input  logic signed [COEF_W-1:0] a1,
   input  logic signed [COEF_W-1:0] a2,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_sample
);
   localparam int PW = COEF_W + STATE_W;

   logic signed [STATE_W-1:0] v1, v2, v_new;
   logic signed [PW-1:0]      p1, p2;
   logic signed [PW+1:0]      acc;
   logic signed [63:0]        v64, y64;
   logic signed [STATE_W:0]   dv;
   logic signed [PW:0]        yp;

   assign p1    = a1 * v1;
   assign p2    = a2 * v2;
   assign acc   = ((PW + 2)'(in_sample) <<< COEF_FRAC) - (PW + 2)'(p1) - (PW + 2)'(p2);
   assign v64   = clamp_s64(64'(acc >>> COEF_FRAC), STATE_W);
   assign v_new = v64[STATE_W-1:0];
   assign dv    = (STATE_W + 1)'(v_new) - (STATE_W + 1)'(v2);
   assign yp    = b0 * dv;
   assign y64   = clamp_s64(64'(yp >>> COEF_FRAC), DATA_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1         <= '0;
         v2         <= '0;
         out_sample <= '0;
         out_valid  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            v1         <= v_new;
            v2         <= v1;
            out_sample <= y64[DATA_W-1:0];
         end
      end
   end
endmodule

// File: rtl/wah_filter.sv
module wah_filter #(
   parameter int DATA_W    = 24,
   parameter int COEF_W    = 24,
   parameter int COEF_FRAC = 21,
   parameter int STATE_W   = 32,
   parameter int Q_W       = 16,
   parameter int Q_FRAC    = 12,
   parameter int ENV_SHIFT = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic        [Q_W-1:0]    q_factor,
   input  logic        [DATA_W-1:0] freq_offset,
   input  logic        [DATA_W-1:0] swing,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_sample
);
   generate
      if (COEF_FRAC >= COEF_W - 2) begin : g_bad_coef
         $error("coefficient format needs at least two integer bits");
      end
      if (STATE_W <= DATA_W || COEF_W + STATE_W + 2 > 64) begin : g_bad_state
         $error("state width out of range");
      end
      if (Q_FRAC > DATA_W - 1 || Q_FRAC >= Q_W) begin : g_bad_q
         $error("Q fraction width out of range");
      end
      if (ENV_SHIFT < 0 || ENV_SHIFT >= DATA_W) begin : g_bad_env
         $error("envelope shift out of range");
      end
   endgenerate

   logic        [DATA_W-1:0] env_q;
   logic signed [COEF_W-1:0] coef_b0, coef_a1, coef_a2;

   wah_env_follower #(.DATA_W(DATA_W), .ENV_SHIFT(ENV_SHIFT)) u_env (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_sample(in_sample), .env(env_q)
   );

   wah_coef_engine #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
      .Q_W(Q_W), .Q_FRAC(Q_FRAC)
   ) u_coef (
      .clk(clk), .rst_n(rst_n), .commit(in_valid), .env(env_q),
      .offset(freq_offset), .swing(swing), .q(q_factor),
      .b0(coef_b0), .a1(coef_a1), .a2(coef_a2)
   );

   wah_biquad_df2 #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .STATE_W(STATE_W)
   ) u_iir (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .b0(coef_b0), .a1(coef_a1), .a2(coef_a2),
      .out_valid(out_valid), .out_sample(out_sample)
   );
endmodule

// File: rtl/wah_filter_chk.sv
module wah_filter_chk #(
   parameter int DATA_W = 24,
   parameter int COEF_W = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_sample,
   input logic        [DATA_W-1:0] env,
   input logic signed [COEF_W-1:0] b0,
   input logic signed [COEF_W-1:0] a1,
   input logic signed [COEF_W-1:0] a2
);
   localparam logic [DATA_W-1:0] ENV_MAX = DATA_W'(1) << (DATA_W - 1);

   p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sample));

   p_coef_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(b0) && $stable(a1) && $stable(a2)));

   p_env_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      env <= ENV_MAX);

   p_b0_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      b0 >= 0);
endmodule

bind wah_filter wah_filter_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
   .out_sample(out_sample), .env(env_q),
   .b0(coef_b0), .a1(coef_a1), .a2(coef_a2)
);

// File: tb/tb_wah_filter.sv
module tb_wah_filter;
   localparam int  SPACING = 256;
   localparam real FS      = 8388608.0;
   localparam real QS      = 4096.0;
   localparam real ENV_DIV = 16.0;
   localparam real VMAX    = 256.0;
   localparam real TOL     = 1.0e-3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic signed [23:0] in_sample = '0;
   logic [15:0] q_factor = 16'd4096;
   logic [23:0] freq_offset = '0;
   logic [23:0] swing = '0;
   logic        out_valid;
   logic signed [23:0] out_sample;

   always #5 clk = ~clk;

   wah_filter dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .q_factor(q_factor), .freq_offset(freq_offset), .swing(swing),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference model state
   int  m_n;
   real m_env, m_v1, m_v2;
   real h_env[0:63];
   real h_q[0:63];
   real h_off[0:63];
   real h_sw[0:63];
   int  cur_q, cur_off, cur_sw;
   bit  m_sat_seen;

   task automatic check_bit(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic check_val(input string tag, input int got, input real exp_r);
      int  exp_i;
      real diff;
      checks++;
      exp_i = $rtoi(exp_r * FS);
      diff  = (got - exp_r * FS) / FS;
      if (diff < 0.0) diff = -diff;
      if (diff > TOL) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp_i);
      end
   endtask

   task automatic do_reset(input int q_i, input int off_i, input int sw_i);
      cur_q = q_i; cur_off = off_i; cur_sw = sw_i;
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
      q_factor = 16'(q_i); freq_offset = 24'(off_i); swing = 24'(sw_i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      m_n = 0; m_env = 0.0; m_v1 = 0.0; m_v2 = 0.0; m_sat_seen = 1'b0;
      h_env[0] = 0.0; h_q[0] = q_i / QS; h_off[0] = off_i / FS; h_sw[0] = sw_i / FS;
      repeat (SPACING) @(negedge clk);
   endtask

   task automatic send(input real xr, input string tag);
      int  xi, got, n;
      real x, b0, a1, a2, w, d, q, v, y, sq;
      n  = m_n;
      xi = $rtoi(xr * FS);
      if (xi > 8388607) xi = 8388607;
      if (xi < -8388608) xi = -8388608;
      x = xi / FS;
      if (n == 0) begin
         b0 = 0.0; a1 = 0.0; a2 = 0.0;
      end else begin
         q = h_q[n-1];
         w = h_off[n-1] + h_sw[n-1] * h_env[n-1];
         if (w > 1.0) w = 1.0;
         d  = w + q + q * w * w;
         b0 = w / d;
         a1 = 2.0 * (q * w * w - q) / d;
         a2 = (q * w * w - w + q) / d;
      end
      v = x - a1 * m_v1 - a2 * m_v2;
      if (v > VMAX) begin v = VMAX; m_sat_seen = 1'b1; end
      if (v < -VMAX) begin v = -VMAX; m_sat_seen = 1'b1; end
      y = b0 * (v - m_v2);
      if (y > 8388607.0 / FS) y = 8388607.0 / FS;
      if (y < -1.0) y = -1.0;
      m_v2 = m_v1; m_v1 = v;
      sq = $floor((1.0 * xi) * (1.0 * xi) / FS) / FS;
      m_env = m_env + (sq - m_env) / ENV_DIV;
      h_env[n+1] = m_env; h_q[n+1] = cur_q / QS;
      h_off[n+1] = cur_off / FS; h_sw[n+1] = cur_sw / FS;
      m_n = n + 1;

      @(negedge clk);
      in_valid = 1'b1; in_sample = 24'(xi);
      q_factor = 16'(cur_q); freq_offset = 24'(cur_off); swing = 24'(cur_sw);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit({tag, " out_valid after strobe (R1)"}, out_valid, 1'b1);
      got = int'(out_sample);
      check_val(tag, got, y);
      @(negedge clk);
      check_bit({tag, " out_valid single pulse (R1)"}, out_valid, 1'b0);
      repeat (SPACING - 3) @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset(8192, 1677722, 0);
      check_bit("R2 reset out_valid", out_valid, 1'b0);
      check_val("R2 reset out_sample", int'(out_sample), 0.0);
   endtask

   task automatic t_first_zero();
      do_reset(8192, 1677722, 0);
      send(0.5, "R2 first sample zero");
      for (int i = 0; i < 5; i++) send(0.25 * (i % 2 == 0 ? 1.0 : -1.0), "R6 alternating");
   endtask

   task automatic t_impulse();
      do_reset(8192, 838861, 0);
      send(0.0, "R6 silence");
      send(0.0, "R6 silence");
      send(0.5, "R8 impulse same-sample response");
      for (int i = 0; i < 20; i++) send(0.0, "R5 R6 impulse tail");
   endtask

   task automatic t_envelope();
      do_reset(6144, 419430, 6710886);
      for (int i = 0; i < 40; i++)
         send(0.6 * $sin(6.283185307 * i / 10.0), "R3 R7 envelope sweep");
   endtask

   task automatic t_clamp();
      do_reset(4096, 7549747, 15938355);
      for (int i = 0; i < 24; i++)
         send((i % 2 == 0) ? 0.9 : -0.9, "R4 tuning clamp");
   endtask

   task automatic t_saturate();
      int held;
      do_reset(4096, 83886, 0);
      for (int i = 0; i < 48; i++) send(0.999, "R9 state saturation");
      if (!m_sat_seen) $display("note: reference model did not reach the state limit");
      held = int'(out_sample);
      for (int i = 0; i < 6; i++) begin
         repeat (50) @(negedge clk);
         check_bit("R1 idle out_valid", out_valid, 1'b0);
         check_val("R1 idle out_sample hold", int'(out_sample), held / FS);
      end
   endtask

   task automatic t_param_change();
      do_reset(4096, 1258291, 0);
      for (int i = 0; i < 10; i++) send(0.3 * $sin(6.283185307 * i / 7.0), "R10 before change");
      cur_q = 16384; cur_off = 2516582;
      for (int i = 10; i < 26; i++) send(0.3 * $sin(6.283185307 * i / 7.0), "R10 after change");
   endtask

   initial begin
      t_reset_state();
      t_first_zero();
      t_impulse();
      t_envelope();
      t_clamp();
      t_saturate();
      t_param_change();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule